// File: doc/BRIEF.md
# Dual-Radio Time-Slot Coexistence Arbiter

This block lets a classic link and a low-energy link share a single radio by dividing time into a repeating superframe. The superframe has ten equal slots. With default parameters each slot is 625 ticks of a 1 MHz enable, so the superframe is 6250 µs. A split value N gives slots 0 to N-1 to the classic link and the remaining slots to the low-energy link. A split above ten is treated as ten. A new split value is only taken in at a superframe boundary, so a superframe never changes its layout part of the way through.

At every slot boundary a three-state controller (idle, classic active, low-energy active) looks at the pending-traffic input of the link that owns the next slot. If that link has nothing pending, the controller goes idle for the whole slot and both grants stay low. When the owner of the new slot differs from the owner of the slot before it, a guard interval of `GUARD_TICKS` ticks (default 150) is added at the start of the new slot so the synthesizer can relock. No grant is given during the guard. The block also raises a low-energy anchor pulse once every `conn_ival` superframes. Because the pulse can only fall on a superframe boundary, the connection interval is always a whole number of superframes.

Top module: `coex_arbiter`

## Requirements
- R1: While reset is held, grant_classic, grant_le, guard_active, superframe_start and le_anchor are 0 and slot_index is 0.
- R2: slot_index advances by one after every SLOT_TICKS asserted ticks and wraps from 9 to 0. Cycles with tick_1us low do not advance it.
- R3: superframe_start is high for exactly one clock cycle, in the cycle in which slot_index has just become 0.
- R4: A slot whose index is below the active split belongs to the classic link. Every other slot belongs to the low-energy link. A split_cfg value above 10 behaves as 10.
- R5: split_cfg is sampled only at the edge that starts a new superframe. A change made in the middle of a superframe first affects slot 0 of the next superframe.
- R6: If the owner of a slot has its pending input low at the edge that starts the slot, the controller stays idle for the whole slot and both grants are 0. Pending changes in the middle of a slot are ignored until the next slot boundary.
- R7: When a slot's owner differs from the previous slot's owner, guard_active is 1 for the first GUARD_TICKS ticks of the slot and both grants are 0 during that time. When the owner is unchanged, no guard is inserted.
- R8: At most one grant is high at any time. A grant is only given to the owner of the current slot.
- R9: le_anchor pulses together with superframe_start on every conn_ival-th superframe boundary after reset. A conn_ival of 0 behaves as 1.
- R10: The first slot after reset is idle, with both grants 0, whatever the pending inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | Timebase enable, one cycle per microsecond |
| split_cfg | input | SPLIT_W | Number of classic slots per superframe, saturated to 10 |
| conn_ival | input | IVAL_W | Low-energy connection interval in superframes |
| pend_classic | input | 1 | Classic link has traffic pending |
| pend_le | input | 1 | Low-energy link has a connection event pending |
| grant_classic | output | 1 | Radio granted to the classic link |
| grant_le | output | 1 | Radio granted to the low-energy link |
| guard_active | output | 1 | Relock guard interval in progress |
| slot_index | output | IDX_W | Current slot number, 0 to 9 |
| superframe_start | output | 1 | One-cycle pulse at the start of each superframe |
| le_anchor | output | 1 | One-cycle low-energy anchor event pulse |

## Verification
Every output is registered. Slot index, controller state, superframe pulse and anchor change in the clock cycle right after the edge that takes in the tick completing a slot. guard_active drops in the cycle after the edge that takes in the GUARD_TICKS-th following tick. The bench's prediction runs at each rising edge from its own count of ticks taken in since reset, and pushes one expected record per cycle into a queue. The monitor pops that record at the following falling edge, so each comparison sees exactly the edge the prediction describes. Pending and split inputs change only at falling edges, so the boundary edge that samples them is clear.

// File: rtl/coex_pkg.sv
package coex_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CLASSIC = 2'd1,
    ST_LE      = 2'd2
  } coex_state_e;

  typedef enum logic {
    OWN_CLASSIC = 1'b0,
    OWN_LE      = 1'b1
  } owner_e;

  // Clamp a programmed split to the number of slots in a superframe.
  function automatic int sat_split(input int raw, input int lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // Slot index following cur, wrapping at the end of the superframe.
  function automatic int next_slot(input int cur, input int slots);
    return (cur >= slots - 1) ? 0 : cur + 1;
  endfunction

  // Owner of a slot given the active split: leading slots are classic.
  function automatic owner_e slot_owner(input int idx, input int split);
    return (idx < split) ? OWN_CLASSIC : OWN_LE;
  endfunction

  // Whether an anchor is due; an interval of zero acts as one.
  function automatic logic interval_reached(input int cnt, input int ival);
    int eff;
    eff = (ival == 0) ? 1 : ival;
    return cnt >= eff - 1;
  endfunction

  // State entered for a slot given its owner and that owner's demand.
  function automatic coex_state_e slot_state(input owner_e own,
                                             input logic pend_c,
                                             input logic pend_l);
    if (own == OWN_CLASSIC) return pend_c ? ST_CLASSIC : ST_IDLE;
    return pend_l ? ST_LE : ST_IDLE;
  endfunction

endpackage

// File: rtl/coex_slot_timer.sv
module coex_slot_timer
  import coex_pkg::*;
#(
  parameter int SLOT_TICKS = 625,
  parameter int SLOTS      = 10,
  parameter int IDX_W      = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic             slot_end,
  output logic             frame_end
);

  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SLOT_TICKS - 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(SLOTS - 1);

  logic [TICK_W-1:0] tick_cnt;

  // Events of this edge, exported for the other stages and the checks.
  assign slot_end  = tick && (tick_cnt == LAST_TICK);
  assign frame_end = slot_end && (slot_idx == LAST_SLOT);
  assign next_idx  = IDX_W'(next_slot(int'(slot_idx), SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      slot_idx <= '0;
    end else if (tick) begin
      if (slot_end) begin
        tick_cnt <= '0;
        slot_idx <= next_idx;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_idx) < SLOTS);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot_idx));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !frame_end) |=> (slot_idx == $past(slot_idx) + 1'b1));

endmodule

// File: rtl/coex_frame_ctrl.sv
module coex_frame_ctrl
  import coex_pkg::*;
#(
  parameter int SLOTS   = 10,
  parameter int SPLIT_W = 4,
  parameter int IVAL_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [SPLIT_W-1:0] split_cfg,
  input  logic [IVAL_W-1:0]  conn_ival,
  output logic [SPLIT_W-1:0] split_next,
  output logic               sf_start,
  output logic               le_anchor
);

  localparam logic [SPLIT_W-1:0] SPLIT_RST = SPLIT_W'(SLOTS);

  logic [SPLIT_W-1:0] split_act;
  logic [SPLIT_W-1:0] split_sat;
  logic [IVAL_W-1:0]  anc_cnt;
  logic               anchor_due;

  assign split_sat  = SPLIT_W'(sat_split(int'(split_cfg), SLOTS));
  // The slot decided at a frame edge is slot 0 of the new frame.
  assign split_next = frame_end ? split_sat : split_act;
  assign anchor_due = interval_reached(int'(anc_cnt), int'(conn_ival));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_act <= SPLIT_RST;
      anc_cnt   <= '0;
      sf_start  <= 1'b0;
      le_anchor <= 1'b0;
    end else begin
      sf_start  <= frame_end;
      le_anchor <= frame_end && anchor_due;
      if (frame_end) begin
        split_act <= split_sat;
        anc_cnt   <= anchor_due ? '0 : anc_cnt + 1'b1;
      end
    end
  end

  a_r5_split_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(split_act));

  a_r4_split_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(split_act) <= SLOTS);

  a_r9_anchor_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    le_anchor |-> sf_start);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> !sf_start);

endmodule

// File: rtl/coex_owner_fsm.sv
module coex_owner_fsm
  import coex_pkg::*;
#(
  parameter int SLOTS       = 10,
  parameter int GUARD_TICKS = 150,
  parameter int IDX_W       = $clog2(SLOTS),
  parameter int SPLIT_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               slot_end,
  input  logic [IDX_W-1:0]   next_idx,
  input  logic [SPLIT_W-1:0] split_next,
  input  logic               pend_classic,
  input  logic               pend_le,
  output logic               grant_classic,
  output logic               grant_le,
  output logic               guard_active
);

  localparam int GUARD_W = $clog2(GUARD_TICKS + 1);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD_TICKS);

  coex_state_e        state;
  owner_e             cur_owner;
  owner_e             nxt_owner;
  logic               owner_flip;
  logic [GUARD_W-1:0] guard_cnt;

  assign nxt_owner  = slot_owner(int'(next_idx), int'(split_next));
  assign owner_flip = (nxt_owner != cur_owner);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_owner <= OWN_CLASSIC;
      guard_cnt <= '0;
    end else if (slot_end) begin
      state     <= slot_state(nxt_owner, pend_classic, pend_le);
      cur_owner <= nxt_owner;
      guard_cnt <= owner_flip ? GUARD_LOAD : '0;
    end else if (tick && (guard_cnt != '0)) begin
      guard_cnt <= guard_cnt - 1'b1;
    end
  end

  assign guard_active  = (guard_cnt != '0);
  assign grant_classic = (state == ST_CLASSIC) && !guard_active;
  assign grant_le      = (state == ST_LE) && !guard_active;

  a_r8_grant_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_classic && grant_le));

  a_r8_grant_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_le |-> cur_owner == OWN_LE) and (grant_classic |-> cur_owner == OWN_CLASSIC));

  a_r7_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    guard_active |-> !(grant_classic || grant_le));

  a_r7_guard_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_active) |-> $past(slot_end));

  a_r6_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(state));

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int SLOT_TICKS  = 625,
  parameter int GUARD_TICKS = 150,
  parameter int SLOTS       = 10,
  parameter int SPLIT_W     = 4,
  parameter int IVAL_W      = 8,
  parameter int IDX_W       = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1us,
  input  logic [SPLIT_W-1:0] split_cfg,
  input  logic [IVAL_W-1:0]  conn_ival,
  input  logic               pend_classic,
  input  logic               pend_le,
  output logic               grant_classic,
  output logic               grant_le,
  output logic               guard_active,
  output logic [IDX_W-1:0]   slot_index,
  output logic               superframe_start,
  output logic               le_anchor
);

  logic [IDX_W-1:0]   next_idx;
  logic               slot_end;
  logic               frame_end;
  logic [SPLIT_W-1:0] split_next;

  coex_slot_timer #(
    .SLOT_TICKS(SLOT_TICKS),
    .SLOTS     (SLOTS),
    .IDX_W     (IDX_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1us),
    .slot_idx (slot_index),
    .next_idx (next_idx),
    .slot_end (slot_end),
    .frame_end(frame_end)
  );

  coex_frame_ctrl #(
    .SLOTS  (SLOTS),
    .SPLIT_W(SPLIT_W),
    .IVAL_W (IVAL_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .split_cfg (split_cfg),
    .conn_ival (conn_ival),
    .split_next(split_next),
    .sf_start  (superframe_start),
    .le_anchor (le_anchor)
  );

  coex_owner_fsm #(
    .SLOTS      (SLOTS),
    .GUARD_TICKS(GUARD_TICKS),
    .IDX_W      (IDX_W),
    .SPLIT_W    (SPLIT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_1us),
    .slot_end     (slot_end),
    .next_idx     (next_idx),
    .split_next   (split_next),
    .pend_classic (pend_classic),
    .pend_le      (pend_le),
    .grant_classic(grant_classic),
    .grant_le     (grant_le),
    .guard_active (guard_active)
  );

  a_r3_frame_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    superframe_start |-> (slot_index == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !(grant_classic || grant_le || guard_active || superframe_start || le_anchor));

endmodule

// File: tb/sim_coex_arbiter.sv
module sim_coex_arbiter;

  localparam int S    = 20;
  localparam int G    = 5;
  localparam int NSL  = 10;
  localparam int IVAL = 3;

  typedef struct packed {
    logic       gc;
    logic       gl;
    logic       gd;
    logic       sf;
    logic       an;
    logic [3:0] slot;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] split_cfg = 4'd7;
  logic [7:0] conn_ival = 8'(IVAL);
  logic       pend_c = 1'b1;
  logic       pend_l = 1'b1;

  logic       grant_classic, grant_le, guard_active, superframe_start, le_anchor;
  logic [3:0] slot_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];

  // Model state: everything derived from ticks taken in since reset.
  int   t = 0;
  int   slot_m = 0;
  int   split_m = NSL;
  int   sf_num = 0;
  int   prev_own = 0;   // 0 classic, 1 low-energy
  int   own_m = 0;
  int   st_m = 0;       // 0 idle, 1 classic, 2 low-energy
  bit   flip_m = 0;
  bit   sfp, anc;
  exp_t e;

  always #2 clk = ~clk;

  coex_arbiter #(.SLOT_TICKS(S), .GUARD_TICKS(G)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .split_cfg(split_cfg),
    .conn_ival(conn_ival), .pend_classic(pend_c), .pend_le(pend_l),
    .grant_classic(grant_classic), .grant_le(grant_le),
    .guard_active(guard_active), .slot_index(slot_index),
    .superframe_start(superframe_start), .le_anchor(le_anchor));

  task automatic check_eq(input string req, input string what,
                          input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0d", req, what, act, expv, t);
    end
  endtask

  // Predictor: pushes the outputs expected after this edge.
  task automatic predict();
    sfp = 0;
    anc = 0;
    if (tick) begin
      t++;
      if (t % S == 0) begin
        slot_m = (t / S) % NSL;
        if (slot_m == 0) begin
          sf_num++;
          split_m = (int'(split_cfg) > NSL) ? NSL : int'(split_cfg);
          sfp = 1;
          anc = (sf_num % IVAL) == 0;
        end
        own_m = (slot_m < split_m) ? 0 : 1;
        flip_m = (own_m != prev_own);
        prev_own = own_m;
        if (own_m == 0) st_m = pend_c ? 1 : 0;
        else            st_m = pend_l ? 2 : 0;
      end
    end
    e.gd   = flip_m && ((t % S) < G);
    e.gc   = (st_m == 1) && !e.gd;
    e.gl   = (st_m == 2) && !e.gd;
    e.sf   = sfp;
    e.an   = anc;
    e.slot = 4'(slot_m);
    q.push_back(e);
  endtask

  always @(posedge clk) if (rst_n) predict();

  // Monitor: compares at the falling edge after each prediction.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check_eq("R4 R5 R6 R8 R10", "grant_classic", int'(grant_classic), int'(x.gc));
      check_eq("R4 R5 R6 R8 R10", "grant_le", int'(grant_le), int'(x.gl));
      check_eq("R7", "guard_active", int'(guard_active), int'(x.gd));
      check_eq("R2", "slot_index", int'(slot_index), int'(x.slot));
      check_eq("R3", "superframe_start", int'(superframe_start), int'(x.sf));
      check_eq("R9", "le_anchor", int'(le_anchor), int'(x.an));
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tick = 1'b1;
    run(4);
    // R1: quiet outputs while reset is held.
    check_eq("R1", "grant_classic", int'(grant_classic), 0);
    check_eq("R1", "grant_le", int'(grant_le), 0);
    check_eq("R1", "guard_active", int'(guard_active), 0);
    check_eq("R1", "slot_index", int'(slot_index), 0);
    check_eq("R1", "superframe_start", int'(superframe_start), 0);
    check_eq("R1", "le_anchor", int'(le_anchor), 0);
    rst_n = 1'b1;
    run(3);
    // R10: first slot idle although both links are pending.
    check_eq("R10", "grant_classic first slot", int'(grant_classic), 0);
    check_eq("R10", "grant_le first slot", int'(grant_le), 0);
    run(450);
    // R4: oversize split saturates to all-classic.
    split_cfg = 4'd15;
    run(400);
    // R5: mid-superframe change to split 3.
    run(100);
    split_cfg = 4'd3;
    run(400);
    // R6: low-energy owner idle, then classic demand toggling mid-slot.
    pend_l = 1'b0;
    run(250);
    pend_l = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (i % 37 == 0) pend_c = ~pend_c;
      @(negedge clk);
    end
    pend_c = 1'b1;
    // All slots low-energy.
    split_cfg = 4'd0;
    run(400);
    // R2: ticks with gaps, split 5.
    split_cfg = 4'd5;
    for (int i = 0; i < 1500; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b1;
    run(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule